// File: doc/BRIEF.md
# SMBus host status and dispatch registers

This block sits between an 8-bit register port and a bus engine that shifts SMBus bits. Software loads the target address byte, the command byte, two data bytes and, for block transfers, a byte buffer. It then writes the control register with the start bit set. The block decides whether the transaction may go out. If it may, it raises a request toward the engine and holds the request until the engine signals completion. On completion it posts status flags and captures any returned read data.

The status register follows write-one-to-clear rules. A pending device-error flag acts as a lock: no transaction leaves the block until software clears that flag. The block buffer has a single byte index, and every access through the register port advances it. Any write to the status register returns the index to zero.

Top module: `smbus_host_regs`

## Requirements
- R1: After reset the status register, the control register, all data registers, `irq` and `eng_req` read zero.
- R2: Register offsets: 0 status, 1 control, 2 command, 3 address, 4 data0, 5 data1, 6 block data. Control layout: bit 0 interrupt enable, bits 3:1 protocol, bit 7 start (write only, reads 0). A start with a valid protocol, while not busy and with status bit 2 clear, sets status bit 0 (busy) and raises `eng_req` on the next cycle. The request carries `eng_taddr` = address[7:1], `eng_rnw` = address[0], the protocol and the command, all captured at the start.
- R3: While a request is outstanding, `eng_wdata` is {data1, data0} (data1 in the high byte) and `eng_count` equals data0.
- R4: An `eng_done` pulse while busy clears status bit 0 and drops `eng_req`. In the same cycle it sets status bit 7 (byte done) and bit 1 (interrupt) together.
- R5: The valid protocol codes are 0, 1, 2, 3 and 5. A start with any other code sets status bit 2 (device error) and raises no request.
- R6: While status bit 2 is set, a start raises no request and bit 2 stays set.
- R7: A start while busy is ignored. It does not set device error and does not change the protocol in flight.
- R8: A status write clears exactly the bits 7..1 written as one and keeps the others. Bit 0 is not affected by software writes.
- R9: Any status write resets the block-buffer index to zero.
- R10: Block-data writes and reads each use the current index and then increment it. The engine reads the buffer at `eng_blk_idx` through `eng_blk_rbyte`, and writes it with `eng_blk_we`.
- R11: On completion of a read (address bit 0 = 1), protocols 1 and 2 load data0 from `eng_rdata[7:0]`. Protocol 3 loads data0 from `eng_rdata[7:0]` and data1 from `eng_rdata[15:8]`.
- R12: `irq` is high exactly when status bit 1 and control bit 0 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rd | input | 1 | Register read strobe (advances block index) |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| eng_req | output | 1 | Transaction request to the bus engine |
| eng_proto | output | 3 | Protocol of the request |
| eng_rnw | output | 1 | Direction, 1 = read |
| eng_taddr | output | 7 | 7-bit target address |
| eng_cmd | output | 8 | Command byte |
| eng_wdata | output | 16 | Write data {data1, data0} |
| eng_count | output | 8 | Block byte count |
| eng_done | input | 1 | Engine completion pulse |
| eng_rdata | input | 16 | Read data from engine |
| eng_blk_idx | input | 5 | Engine buffer index |
| eng_blk_rbyte | output | 8 | Buffer byte at engine index |
| eng_blk_we | input | 1 | Engine buffer write strobe |
| eng_blk_wdata | input | 8 | Engine buffer write byte |

## Verification
A stuck busy bit or a device-error flag that fails to clear appears at once as a missing `eng_req` after the next start. The status value read back on the cycle after the write also shows it. A wrong set or clear mask shows up in the very next status read and on `irq` in the same cycle. A block index that is not reset returns the wrong byte on the first block-data read after a status write.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
  localparam int unsigned REG_W = 8;
  localparam logic [2:0] OFS_STS  = 3'd0;
  localparam logic [2:0] OFS_CTL  = 3'd1;
  localparam logic [2:0] OFS_CMD  = 3'd2;
  localparam logic [2:0] OFS_ADR  = 3'd3;
  localparam logic [2:0] OFS_D0   = 3'd4;
  localparam logic [2:0] OFS_D1   = 3'd5;
  localparam logic [2:0] OFS_BLK  = 3'd6;

  localparam int unsigned B_BUSY  = 0;
  localparam int unsigned B_INTR  = 1;
  localparam int unsigned B_DERR  = 2;
  localparam int unsigned B_BDONE = 7;

  typedef enum logic [2:0] {
    P_QUICK = 3'd0, P_BYTE = 3'd1, P_BDATA = 3'd2, P_WDATA = 3'd3, P_BLOCK = 3'd5
  } proto_e;

  function automatic logic proto_ok(input logic [2:0] p);
    return (p == P_QUICK) || (p == P_BYTE) || (p == P_BDATA) ||
           (p == P_WDATA) || (p == P_BLOCK);
  endfunction

  function automatic logic [7:0] flag_next(input logic [7:0] old,
                                           input logic [7:0] clr,
                                           input logic [7:0] set);
    return (old & ~clr) | set;
  endfunction
endpackage

// File: rtl/smbh_status.sv
module smbh_status
  import smbh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_wr,
  input  logic [7:0] sw_wdata,
  input  logic       start_ok,
  input  logic       proto_bad,
  input  logic       done_ok,
  output logic [7:0] sts
);
  logic       busy_q;
  logic [7:0] flags_q;
  logic [7:0] clr_mask, set_mask;

  always_comb begin
    clr_mask = sw_wr ? {sw_wdata[7:1], 1'b0} : 8'h00;
    set_mask = 8'h00;
    if (done_ok) begin
      set_mask[B_BDONE] = 1'b1;
      set_mask[B_INTR]  = 1'b1;
    end
    if (proto_bad) set_mask[B_DERR] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      flags_q <= 8'h00;
    end else begin
      if (start_ok)     busy_q <= 1'b1;
      else if (done_ok) busy_q <= 1'b0;
      flags_q <= flag_next(flags_q, clr_mask, set_mask) & 8'hFE;
    end
  end

  assign sts = {flags_q[7:1], busy_q};

  p_done_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |=> (sts[B_BDONE] && sts[B_INTR] && !sts[B_BUSY]));
  p_w1c_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && !done_ok && !proto_bad) |=> ((sts[7:1] & $past(sw_wdata[7:1])) == 7'd0));
  p_busy_sw_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && !start_ok && !done_ok) |=> (sts[B_BUSY] == $past(sts[B_BUSY])));
endmodule

// File: rtl/smbh_blkbuf.sv
module smbh_blkbuf #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_clr,
  input  logic          sw_wr,
  input  logic          sw_rd,
  input  logic [7:0]    sw_wdata,
  output logic [7:0]    sw_rdata,
  input  logic [IW-1:0] eng_idx,
  output logic [7:0]    eng_rbyte,
  input  logic          eng_we,
  input  logic [7:0]    eng_wdata
);
  logic [7:0]    mem_q [DEPTH];
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
    end else begin
      if (idx_clr)              idx_q <= '0;
      else if (sw_wr || sw_rd)  idx_q <= idx_q + 1'b1;
      if (sw_wr) mem_q[idx_q] <= sw_wdata;
      if (eng_we) mem_q[eng_idx] <= eng_wdata;
    end
  end

  assign sw_rdata  = mem_q[idx_q];
  assign eng_rbyte = mem_q[eng_idx];

  p_idx_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    idx_clr |=> (idx_q == '0));
  p_idx_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_clr && (sw_wr || sw_rd)) |=> (idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/smbus_host_regs.sv
module smbus_host_regs
  import smbh_pkg::*;
#(
  parameter int unsigned BUF_DEPTH = 32,
  localparam int unsigned IW = $clog2(BUF_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    reg_addr,
  input  logic          reg_wr,
  input  logic [7:0]    reg_wdata,
  input  logic          reg_rd,
  output logic [7:0]    reg_rdata,
  output logic          irq,
  output logic          eng_req,
  output logic [2:0]    eng_proto,
  output logic          eng_rnw,
  output logic [6:0]    eng_taddr,
  output logic [7:0]    eng_cmd,
  output logic [15:0]   eng_wdata,
  output logic [7:0]    eng_count,
  input  logic          eng_done,
  input  logic [15:0]   eng_rdata,
  input  logic [IW-1:0] eng_blk_idx,
  output logic [7:0]    eng_blk_rbyte,
  input  logic          eng_blk_we,
  input  logic [7:0]    eng_blk_wdata
);
  logic [3:0] ctl_q;
  logic [7:0] cmd_q, adr_q, d0_q, d1_q;
  logic [2:0] act_proto_q;
  logic [7:0] act_adr_q, act_cmd_q;
  logic [7:0] sts, blk_rdata;

  logic wr_sts, wr_ctl, start_req, busy, derr;
  logic start_ok, proto_bad, done_ok;

  assign wr_sts    = reg_wr && (reg_addr == OFS_STS);
  assign wr_ctl    = reg_wr && (reg_addr == OFS_CTL);
  assign busy      = sts[B_BUSY];
  assign derr      = sts[B_DERR];
  assign start_req = wr_ctl && reg_wdata[7];
  assign start_ok  = start_req && !busy && !derr && proto_ok(reg_wdata[3:1]);
  assign proto_bad = start_req && !busy && !derr && !proto_ok(reg_wdata[3:1]);
  assign done_ok   = eng_done && busy;

  smbh_status u_sts (
    .clk(clk), .rst_n(rst_n), .sw_wr(wr_sts), .sw_wdata(reg_wdata),
    .start_ok(start_ok), .proto_bad(proto_bad), .done_ok(done_ok), .sts(sts)
  );

  smbh_blkbuf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .idx_clr(wr_sts),
    .sw_wr(reg_wr && (reg_addr == OFS_BLK)),
    .sw_rd(reg_rd && !reg_wr && (reg_addr == OFS_BLK)),
    .sw_wdata(reg_wdata), .sw_rdata(blk_rdata),
    .eng_idx(eng_blk_idx), .eng_rbyte(eng_blk_rbyte),
    .eng_we(eng_blk_we), .eng_wdata(eng_blk_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0; cmd_q <= '0; adr_q <= '0; d0_q <= '0; d1_q <= '0;
      act_proto_q <= '0; act_adr_q <= '0; act_cmd_q <= '0;
    end else begin
      if (wr_ctl)                            ctl_q <= reg_wdata[3:0];
      if (reg_wr && reg_addr == OFS_CMD)     cmd_q <= reg_wdata;
      if (reg_wr && reg_addr == OFS_ADR)     adr_q <= reg_wdata;
      if (reg_wr && reg_addr == OFS_D0)      d0_q  <= reg_wdata;
      if (reg_wr && reg_addr == OFS_D1)      d1_q  <= reg_wdata;
      if (start_ok) begin
        act_proto_q <= reg_wdata[3:1];
        act_adr_q   <= adr_q;
        act_cmd_q   <= cmd_q;
      end
      if (done_ok && act_adr_q[0]) begin
        if (act_proto_q == P_BYTE || act_proto_q == P_BDATA ||
            act_proto_q == P_WDATA)
          d0_q <= eng_rdata[7:0];
        if (act_proto_q == P_WDATA)
          d1_q <= eng_rdata[15:8];
      end
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFS_STS: reg_rdata = sts;
      OFS_CTL: reg_rdata = {4'h0, ctl_q};
      OFS_CMD: reg_rdata = cmd_q;
      OFS_ADR: reg_rdata = adr_q;
      OFS_D0:  reg_rdata = d0_q;
      OFS_D1:  reg_rdata = d1_q;
      OFS_BLK: reg_rdata = blk_rdata;
      default: reg_rdata = 8'h00;
    endcase
  end

  assign eng_req   = busy;
  assign eng_proto = act_proto_q;
  assign eng_rnw   = act_adr_q[0];
  assign eng_taddr = act_adr_q[7:1];
  assign eng_cmd   = act_cmd_q;
  assign eng_wdata = {d1_q, d0_q};
  assign eng_count = d0_q;
  assign irq       = sts[B_INTR] && ctl_q[0];

  p_start_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> eng_req);
  p_bad_proto_r5: assert property (@(posedge clk) disable iff (!rst_n)
    proto_bad |=> (!eng_req && sts[B_DERR]));
  p_derr_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && derr && !busy) |=> !eng_req);
  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && busy && !eng_done) |=> (eng_req && $stable(eng_proto)));
endmodule

// File: tb/smbus_host_regs_tb.sv
module smbus_host_regs_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic irq, eng_req, eng_rnw;
  logic [2:0] eng_proto;
  logic [6:0] eng_taddr;
  logic [7:0] eng_cmd, eng_count, eng_blk_rbyte;
  logic [15:0] eng_wdata;
  logic eng_done = 1'b0, eng_blk_we = 1'b0;
  logic [15:0] eng_rdata = '0;
  logic [4:0] eng_blk_idx = '0;
  logic [7:0] eng_blk_wdata = '0;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  smbus_host_regs dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq(irq),
    .eng_req(eng_req), .eng_proto(eng_proto), .eng_rnw(eng_rnw),
    .eng_taddr(eng_taddr), .eng_cmd(eng_cmd), .eng_wdata(eng_wdata),
    .eng_count(eng_count), .eng_done(eng_done), .eng_rdata(eng_rdata),
    .eng_blk_idx(eng_blk_idx), .eng_blk_rbyte(eng_blk_rbyte),
    .eng_blk_we(eng_blk_we), .eng_blk_wdata(eng_blk_wdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic done(input logic [15:0] rdat);
    @(negedge clk); eng_done = 1'b1; eng_rdata = rdat;
    @(negedge clk); eng_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(0, v); chk("R1 status", v, 8'h00);
    rd(1, v); chk("R1 control", v, 8'h00);
    rd(4, v); chk("R1 data0", v, 8'h00);
    chk("R1 irq/req", {irq, eng_req}, 2'b00);
  endtask

  task automatic t_word_write();
    logic [7:0] v;
    wr(3, 8'hA4); wr(2, 8'h3C); wr(4, 8'h11); wr(5, 8'h22);
    wr(1, 8'h87);
    chk("R2 req", eng_req, 1'b1);
    chk("R2 fields", {eng_taddr, eng_rnw, eng_proto, eng_cmd}, {7'h52, 1'b0, 3'd3, 8'h3C});
    chk("R3 wdata", eng_wdata, 16'h2211);
    chk("R3 count", eng_count, 8'h11);
    rd(0, v); chk("R2 busy", v, 8'h01);
    wr(0, 8'h01); rd(0, v); chk("R8 busy not sw-clearable", v, 8'h01);
    done(16'h0);
    rd(0, v); chk("R4 status", v, 8'h82);
    chk("R4 req drop", eng_req, 1'b0);
    chk("R12 irq on", irq, 1'b1);
    wr(0, 8'h02); rd(0, v); chk("R8 clear intr only", v, 8'h80);
    chk("R12 irq off", irq, 1'b0);
    wr(0, 8'h80); rd(0, v); chk("R8 clear done", v, 8'h00);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] v;
    wr(1, 8'h80);
    wr(1, 8'h8E);
    rd(0, v); chk("R7 no derr while busy", v, 8'h01);
    chk("R7 proto kept", eng_proto, 3'd0);
    done(16'h0);
    wr(0, 8'hFF); rd(0, v); chk("R8 clear all", v, 8'h00);
  endtask

  task automatic t_bad_and_lock();
    logic [7:0] v;
    wr(1, 8'h88);
    rd(0, v); chk("R5 derr", v, 8'h04);
    chk("R5 no req", eng_req, 1'b0);
    wr(1, 8'h8C);
    rd(0, v); chk("R5 code6 derr", v, 8'h04);
    wr(1, 8'h82);
    chk("R6 no req", eng_req, 1'b0);
    rd(0, v); chk("R6 derr stays", v, 8'h04);
    wr(0, 8'h04); rd(0, v); chk("R8 clear derr", v, 8'h00);
    wr(1, 8'h8A);
    chk("R5 code5 accepted", {eng_req, eng_proto}, {1'b1, 3'd5});
    done(16'h0); wr(0, 8'hFE);
  endtask

  task automatic t_reads();
    logic [7:0] v;
    wr(3, 8'hA5); wr(1, 8'h86);
    chk("R2 rnw", eng_rnw, 1'b1);
    done(16'hBEEF);
    rd(4, v); chk("R11 word d0", v, 8'hEF);
    rd(5, v); chk("R11 word d1", v, 8'hBE);
    wr(0, 8'hFE);
    wr(1, 8'h84); done(16'h1234);
    rd(4, v); chk("R11 byte d0", v, 8'h34);
    rd(5, v); chk("R11 byte keeps d1", v, 8'hBE);
    wr(0, 8'hFE);
  endtask

  task automatic t_block();
    logic [7:0] v;
    wr(0, 8'h00);
    wr(6, 8'hA1); wr(6, 8'hA2); wr(6, 8'hA3);
    @(negedge clk); eng_blk_idx = 5'd1; #1;
    chk("R10 engine read", eng_blk_rbyte, 8'hA2);
    wr(0, 8'h00);
    rd(6, v); chk("R10 read idx0", v, 8'hA1);
    rd(6, v); chk("R10 read idx1", v, 8'hA2);
    wr(0, 8'h00);
    rd(6, v); chk("R9 index reset", v, 8'hA1);
    @(negedge clk); eng_blk_idx = 5'd0; eng_blk_wdata = 8'h5A; eng_blk_we = 1'b1;
    @(negedge clk); eng_blk_we = 1'b0;
    wr(0, 8'h00);
    rd(6, v); chk("R10 engine write", v, 8'h5A);
  endtask

  task automatic t_irq_mask();
    logic [7:0] v;
    wr(1, 8'h80); done(16'h0);
    rd(0, v); chk("R4 status ien off", v, 8'h82);
    chk("R12 masked", irq, 1'b0);
    wr(1, 8'h01);
    chk("R12 enabled", irq, 1'b1);
    wr(0, 8'h82);
    chk("R12 cleared", irq, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_word_write();
    t_busy_ignore();
    t_bad_and_lock();
    t_reads();
    t_block();
    t_irq_mask();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule